// File: doc/BRIEF.md
# Read/Write Drain Mode Arbiter

This block sits in front of a memory channel that keeps separate read and write queues. On every cycle it decides which queue the channel is serving and grants at most one burst from the head of that queue. It sees each queue only as an occupancy count. When a burst is granted, the queue owner is expected to lower the matching count by one on the following cycle.

The policy has hysteresis. Reads are served by default. A full enough write queue forces a switch to writes. A moderately full write queue is drained when no reads are waiting. Once the block has switched to writes, it keeps draining until a minimum batch has been granted, unless the write queue runs dry first. Each change of direction opens a turnaround gap, and grants in the new direction are held back until that gap has passed. The block assumes a single rank, so both gaps always apply.

Top module: `rw_drain_arbiter`

## Requirements
- R1: The write high mark and low mark are entry counts rounded up from percentages of the write queue depth. With the defaults (depth 64, 85 % and 50 %) the high mark is 55 and the low mark is 32.
- R2: In read mode, if `wr_count` is at or above the high mark, `mode_write` is 1 on the next cycle and no read is granted in that cycle, even when reads are pending. At 54 entries, read mode is kept.
- R3: In read mode with `rd_count` = 0, if `wr_count` is at or above the low mark, write mode is entered on the next cycle. At 31 entries, read mode is kept and nothing is granted.
- R4: Write mode is left only after at least MIN_WR_BATCH (16) write grants in the current write episode, or when `wr_count` is 0.
- R5: After entering read mode, no read is granted for WTR_GAP (6) cycles. If reads are pending, the first read grant comes exactly WTR_GAP cycles after the first cycle in which `mode_write` reads 0.
- R6: After entering write mode, no write is granted for RTW_GAP (2) cycles. If writes are pending, the first write grant comes exactly RTW_GAP cycles after the first cycle in which `mode_write` reads 1.
- R7: When no switch is due and the gap has expired, one burst per cycle is granted from the current mode's queue if that queue is not empty. `rd_grant` is only given in read mode and `wr_grant` only in write mode.
- R8: When both counts are 0, `mode_write` holds its value and neither grant is asserted.
- R9: After reset, `mode_write` is 0 (encoding: 0 = read, 1 = write) and no turnaround gap is pending, so a pending read is granted in the first cycle.
- R10: In write mode, once the batch minimum is met, with reads pending and `wr_count` below the high mark, the block switches to read on the next cycle without granting a further write. With reads pending and `wr_count` at 0, it switches even if the minimum is not met.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_count | input | $clog2(RD_DEPTH+1) | Read queue occupancy in bursts |
| wr_count | input | $clog2(WR_DEPTH+1) | Write queue occupancy in bursts |
| mode_write | output | 1 | Current mode: 0 read, 1 write |
| rd_grant | output | 1 | Head read burst granted this cycle |
| wr_grant | output | 1 | Head write burst granted this cycle |

## Verification
The assertions check the following on every cycle:
- The forced and opportunistic entries into write mode.
- That each write episode ends only after the minimum batch or on an empty write queue.
- That no grant falls inside a turnaround window.
- That grants match the current mode.
- That idle queues leave the mode unchanged.

Only the bench's closed-loop scenarios can show the exact cycle of the first grant after each switch and the exact batch length. They also show whether the block returns to reads promptly once the batch is met and drains a whole queue when no reads arrive. The early exit when the write queue is emptied mid-batch is likewise shown only there.

// File: rtl/rwd_pkg.sv
package rwd_pkg;

  typedef enum logic {
    MODE_RD = 1'b0,
    MODE_WR = 1'b1
  } mode_e;

  // entries needed to reach pct percent of depth, rounded up
  function automatic int pct_ceil(input int depth, input int pct);
    return (depth * pct + 99) / 100;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rwd_watermark.sv
module rwd_watermark
  import rwd_pkg::*;
#(
  parameter int RD_DEPTH = 32,
  parameter int WR_DEPTH = 64,
  parameter int HI_PCT   = 85,
  parameter int LO_PCT   = 50,
  parameter int RD_CW    = $clog2(RD_DEPTH + 1),
  parameter int WR_CW    = $clog2(WR_DEPTH + 1)
) (
  input  logic [RD_CW-1:0] rd_count,
  input  logic [WR_CW-1:0] wr_count,
  output logic             wr_high,
  output logic             wr_low_ok,
  output logic             rd_empty,
  output logic             wr_empty
);

  localparam int HI_MARK = pct_ceil(WR_DEPTH, HI_PCT);
  localparam int LO_MARK = pct_ceil(WR_DEPTH, LO_PCT);

  always_comb begin
    wr_high   = (wr_count >= WR_CW'(HI_MARK));
    wr_low_ok = (wr_count >= WR_CW'(LO_MARK)) && (wr_count != '0);
    rd_empty  = (rd_count == '0);
    wr_empty  = (wr_count == '0);
  end

endmodule

// File: rtl/rwd_turnaround.sv
module rwd_turnaround
  import rwd_pkg::*;
#(
  parameter int WTR_GAP = 6,
  parameter int RTW_GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic to_write,
  output logic busy
);

  localparam int GW = $clog2(max2(max2(WTR_GAP, RTW_GAP), 1) + 1);

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (start) begin
      gap_q <= to_write ? GW'(RTW_GAP) : GW'(WTR_GAP);
    end else if (gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end
  end

  assign busy = (gap_q != '0);

endmodule

// File: rtl/rwd_batch_count.sv
module rwd_batch_count #(
  parameter int MIN_WR_BATCH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  output logic met
);

  localparam int BW = $clog2(MIN_WR_BATCH + 1);

  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (inc && (cnt_q < BW'(MIN_WR_BATCH))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign met = (cnt_q >= BW'(MIN_WR_BATCH));

endmodule

// File: rtl/rw_drain_arbiter.sv
module rw_drain_arbiter
  import rwd_pkg::*;
#(
  parameter int RD_DEPTH     = 32,
  parameter int WR_DEPTH     = 64,
  parameter int HI_PCT       = 85,
  parameter int LO_PCT       = 50,
  parameter int MIN_WR_BATCH = 16,
  parameter int WTR_GAP      = 6,
  parameter int RTW_GAP      = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [$clog2(RD_DEPTH+1)-1:0]  rd_count,
  input  logic [$clog2(WR_DEPTH+1)-1:0]  wr_count,
  output logic                           mode_write,
  output logic                           rd_grant,
  output logic                           wr_grant
);

  localparam int RD_CW   = $clog2(RD_DEPTH + 1);
  localparam int WR_CW   = $clog2(WR_DEPTH + 1);
  localparam int HI_MARK = pct_ceil(WR_DEPTH, HI_PCT);
  localparam int LO_MARK = pct_ceil(WR_DEPTH, LO_PCT);
  localparam int MAXGAP  = max2(WTR_GAP, RTW_GAP);
  localparam int SW      = $clog2(MAXGAP + 2);

  mode_e mode_q;
  logic  wr_high, wr_low_ok, rd_empty, wr_empty;
  logic  gap_busy, batch_met;
  logic  switch_now;

  rwd_watermark #(
    .RD_DEPTH(RD_DEPTH), .WR_DEPTH(WR_DEPTH),
    .HI_PCT(HI_PCT), .LO_PCT(LO_PCT),
    .RD_CW(RD_CW), .WR_CW(WR_CW)
  ) u_marks (
    .rd_count (rd_count),
    .wr_count (wr_count),
    .wr_high  (wr_high),
    .wr_low_ok(wr_low_ok),
    .rd_empty (rd_empty),
    .wr_empty (wr_empty)
  );

  rwd_turnaround #(.WTR_GAP(WTR_GAP), .RTW_GAP(RTW_GAP)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (switch_now),
    .to_write(mode_q == MODE_RD),
    .busy    (gap_busy)
  );

  rwd_batch_count #(.MIN_WR_BATCH(MIN_WR_BATCH)) u_batch (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(switch_now),
    .inc  (wr_grant),
    .met  (batch_met)
  );

  // switch decision and grants; a switch cycle grants nothing
  always_comb begin
    switch_now = 1'b0;
    rd_grant   = 1'b0;
    wr_grant   = 1'b0;
    unique case (mode_q)
      MODE_RD: begin
        if (wr_high || (rd_empty && wr_low_ok)) switch_now = 1'b1;
        else if (!rd_empty && !gap_busy)        rd_grant   = 1'b1;
      end
      MODE_WR: begin
        if (!rd_empty && (wr_empty || (batch_met && !wr_high))) switch_now = 1'b1;
        else if (!wr_empty && !gap_busy)                        wr_grant   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          mode_q <= MODE_RD;
    else if (switch_now) mode_q <= (mode_q == MODE_RD) ? MODE_WR : MODE_RD;
  end

  assign mode_write = (mode_q == MODE_WR);

  // ---------------- observation state for the assertions ----------------
  logic          chk_prev_mode_q;
  logic [SW-1:0] chk_since_q;
  logic [SW-1:0] chk_since_now;
  logic [WR_CW:0] chk_ep_wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_prev_mode_q <= 1'b0;
      chk_since_q     <= SW'(MAXGAP + 1);
      chk_ep_wr_q     <= '0;
    end else begin
      chk_prev_mode_q <= mode_write;
      if (mode_write != chk_prev_mode_q)       chk_since_q <= SW'(1);
      else if (chk_since_q < SW'(MAXGAP + 1))  chk_since_q <= chk_since_q + 1'b1;
      if (mode_write && !chk_prev_mode_q)      chk_ep_wr_q <= '0;
      else if (wr_grant && (chk_ep_wr_q < (WR_CW+1)'(MIN_WR_BATCH)))
        chk_ep_wr_q <= chk_ep_wr_q + 1'b1;
    end
  end

  assign chk_since_now = (mode_write != chk_prev_mode_q) ? '0 : chk_since_q;

  p_force_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_write && wr_count >= WR_CW'(HI_MARK)) |=> mode_write);

  p_opp_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_write && rd_count == '0 && wr_count >= WR_CW'(LO_MARK) && wr_count != '0)
      |=> mode_write);

  p_min_batch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_write) |->
      (chk_ep_wr_q >= (WR_CW+1)'(MIN_WR_BATCH) || $past(wr_count) == '0));

  p_rd_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_grant |-> (int'(chk_since_now) >= WTR_GAP));

  p_wr_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_grant |-> (int'(chk_since_now) >= RTW_GAP));

  p_grant_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_grant |-> (!mode_write && rd_count != '0 && !wr_grant)) and
    (wr_grant |-> (mode_write && wr_count != '0)));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_count == '0 && wr_count == '0) |=> $stable(mode_write));

endmodule

// File: tb/rw_drain_arbiter_bench.sv
module rw_drain_arbiter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // vector: read count, write count, expected rd_grant, wr_grant, next mode
  localparam int V_RD [NV] = '{5, 5, 5, 0, 0, 0, 32, 1};
  localparam int V_WR [NV] = '{0, 54, 55, 31, 32, 0, 64, 40};
  localparam int V_RG [NV] = '{1, 1, 0, 0, 0, 0, 0, 1};
  localparam int V_WG [NV] = '{0, 0, 0, 0, 0, 0, 0, 0};
  localparam int V_MD [NV] = '{0, 0, 1, 0, 1, 0, 1, 0};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] rd_count = '0;
  logic [6:0] wr_count = '0;
  logic       mode_write, rd_grant, wr_grant;

  int n_run = 0, n_fail = 0;
  int rc = 0, wc = 0;
  int s_mode, s_rg, s_wg;
  int prev_mode, since_flip, wr_ep, last_ep, wr_delay, rd_delay, flips_r;
  bit wr_seen, rd_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  rw_drain_arbiter u_rw_drain_arbiter (
    .clk(clk), .rst_n(rst_n), .rd_count(rd_count), .wr_count(wr_count),
    .mode_write(mode_write), .rd_grant(rd_grant), .wr_grant(wr_grant)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one closed-loop cycle: drive counts, sample, track episodes, pop granted bursts
  task automatic step();
    @(negedge clk);
    rd_count = 6'(rc);
    wr_count = 7'(wc);
    #1;
    s_mode = int'(mode_write);
    s_rg   = int'(rd_grant);
    s_wg   = int'(wr_grant);
    if (s_mode != prev_mode) begin
      since_flip = 0;
      if (s_mode == 1) begin wr_ep = 0; wr_seen = 0; end
      else begin last_ep = wr_ep; rd_seen = 0; flips_r++; end
    end else begin
      since_flip++;
    end
    if (s_wg == 1) begin
      if (!wr_seen) begin wr_delay = since_flip; wr_seen = 1; end
      wr_ep++;
    end
    if (s_rg == 1 && !rd_seen) begin rd_delay = since_flip; rd_seen = 1; end
    if (s_rg == 1) rc--;
    if (s_wg == 1) wc--;
    prev_mode = s_mode;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rc = 0; wc = 0;
    rd_count = '0; wr_count = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    prev_mode = 0; since_flip = 100; wr_ep = 0; last_ep = -1;
    wr_delay = -1; rd_delay = -1; flips_r = 0; wr_seen = 1; rd_seen = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1 marks restated by search: smallest count reaching the percentage
    begin
      int hi_b, lo_b;
      hi_b = 0; lo_b = 0;
      for (int n = 64; n >= 0; n--) begin
        if (n * 100 >= 64 * 85) hi_b = n;
        if (n * 100 >= 64 * 50) lo_b = n;
      end
      check(hi_b == 55 && V_WR[2] == hi_b, "R1 high mark", hi_b, 55);
      check(lo_b == 32 && V_WR[4] == lo_b, "R1 low mark", lo_b, 32);
    end

    // vector table, each from a fresh reset in read mode
    for (int i = 0; i < NV; i++) begin
      do_reset();
      rc = V_RD[i]; wc = V_WR[i];
      step();
      check(s_rg == V_RG[i], $sformatf("R2/R3/R7 vec%0d rd_grant", i), s_rg, V_RG[i]);
      check(s_wg == V_WG[i], $sformatf("R7 vec%0d wr_grant", i), s_wg, V_WG[i]);
      step();
      check(s_mode == V_MD[i], $sformatf("R2/R3/R8 vec%0d mode", i), s_mode, V_MD[i]);
    end

    // R9 reset state and immediate read grant
    do_reset();
    #1;
    check(mode_write == 1'b0, "R9 mode after reset", int'(mode_write), 0);
    check(!rd_grant && !wr_grant, "R9 no grant when idle", int'(rd_grant | wr_grant), 0);
    rc = 4; wc = 20;
    for (int k = 0; k < 4; k++) begin
      step();
      check(s_rg == 1, "R7 read per cycle (R9 no gap)", s_rg, 1);
    end
    step();
    check(s_rg == 0 && s_wg == 0 && s_mode == 0, "R3 below low mark idle",
          s_rg + s_wg + s_mode, 0);

    // forced drain: gap, exact batch, prompt return, read gap
    do_reset();
    rc = 10; wc = 55;
    for (int k = 0; k < 200 && flips_r == 0; k++) step();
    check(wr_delay == 2, "R6 first write after RTW gap", wr_delay, 2);
    check(last_ep >= 16, "R4 batch minimum", last_ep, 16);
    check(last_ep == 16, "R10 return once batch met", last_ep, 16);
    check(wc == 39, "R10 writes left in queue", wc, 39);
    for (int k = 0; k < 50 && !rd_seen; k++) step();
    check(rd_delay == 6, "R5 first read after WTR gap", rd_delay, 6);

    // opportunistic drain of a whole queue, then idle hold in write mode
    do_reset();
    rc = 0; wc = 32;
    for (int k = 0; k < 45; k++) step();
    check(wc == 0 && wr_ep == 32, "R3 full drain without reads", wr_ep, 32);
    check(s_mode == 1 && s_wg == 0 && s_rg == 0, "R8 hold write mode when idle",
          s_mode, 1);
    rc = 2;
    for (int k = 0; k < 20 && flips_r == 0; k++) step();
    check(last_ep == 32, "R4 episode count", last_ep, 32);
    for (int k = 0; k < 50 && !rd_seen; k++) step();
    check(rd_delay == 6, "R5 read gap after idle drain", rd_delay, 6);

    // early exit: write queue emptied before the batch is complete
    do_reset();
    rc = 0; wc = 32;
    for (int k = 0; k < 50 && wr_ep < 5; k++) step();
    check(s_mode == 1 && s_rg == 0, "R4 writes continue under minimum", s_mode, 1);
    wc = 0; rc = 4;
    step();
    check(s_mode == 1 && s_wg == 0, "R10 switch cycle grants nothing", s_wg, 0);
    step();
    check(s_mode == 0, "R10 leave on empty write queue", s_mode, 0);
    check(last_ep == 5, "R4 early exit count", last_ep, 5);
    for (int k = 0; k < 50 && !rd_seen; k++) step();
    check(rd_delay == 6, "R5 read gap after early exit", rd_delay, 6);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule